// File: doc/BRIEF.md
# UART FIFO Interrupt Status Unit

This unit sits beside the receive and transmit FIFOs of a serial port and turns their fill levels into interrupt status. It watches the push and pop strobes and the occupancy counts of both queues, together with a once-per-character tick from the baud generator. From these it keeps five status sources: receive overflow, receive level above a threshold, receive idle timeout, transmit queue empty and transmit level below a threshold. Each source has its own mask bit, and the masked sources are ORed onto a single interrupt line.

Software reaches the unit through a small register port with a write strobe, a two-bit address and a combinational read mux. One word combines the five mask bits, the five status bits and a receive-not-empty flag. A second word holds the two fill thresholds. A third holds the idle-timeout limit in character times and two self-clearing queue flush bits. A fourth returns the current transmit fill count, so a driver can compute free space as depth minus fill. The FIFO storage, serial framing and bus decoding are outside the unit. Its only outputs are the interrupt, the register read data and the two flush pulses sent to the queues.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset all mask bits are 0, both thresholds read DEPTH/2 (8), the timeout limit reads 1, the interrupt is low and both flush outputs are low.
- R2: A push while the receive count equals DEPTH, with no pop in the same cycle, sets overflow status (word 0 bit 8) on the next clock. The bit stays set until a pop or a receive flush clears it.
- R3: Receive-threshold status (word 0 bit 9) is 1 exactly when the receive count is strictly greater than the receive threshold (word 1 bits 4:0).
- R4: While the receive count is nonzero, the idle counter advances on each character tick up to the limit (word 2 bits 3:0). Timeout status (word 0 bit 10) is set when the counter reaches a nonzero limit. A push, a pop or an empty receive queue restarts the counter, and a limit of 0 disables the source.
- R5: Transmit-empty status (word 0 bit 11) is 1 exactly when the transmit count is 0.
- R6: Transmit-below status (word 0 bit 12) is 1 exactly when the transmit count is strictly less than the transmit threshold (word 1 bits 12:8).
- R7: The interrupt equals the OR over the five sources of status AND mask (word 0 bits 4:0, in the same source order as bits 12:8). A mask write takes effect at the clock that captures it, so writing all zeros drops the interrupt on that clock.
- R8: Word 3 bits 4:0 return the current transmit fill count.
- R9: Word 0 bit 15 reads 1 whenever the receive count is nonzero. It has no mask and never drives the interrupt.
- R10: Writing 1 to word 2 bit 8 (receive) or bit 9 (transmit) drives the matching flush output high for exactly one cycle, and the bits read back as 0. A receive flush clears overflow status and restarts the idle counter.
- R11: Writes to word 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe (data register read) |
| rx_count | input | 5 | Receive FIFO occupancy, 0..DEPTH |
| tx_count | input | 5 | Transmit FIFO occupancy, 0..DEPTH |
| char_tick | input | 1 | One pulse per character time |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| irq | output | 1 | Combined masked interrupt |
| rx_flush | output | 1 | One-cycle receive FIFO flush |
| tx_flush | output | 1 | One-cycle transmit FIFO flush |

## Verification
The bench targets the threshold boundaries (count equal to the threshold against one above or below it). A design comparing with >= instead of > would raise the receive level interrupt one entry early. Overflow is checked for stickiness across idle cycles and for a push and a pop in the same cycle at full depth. A design that decays the bit, or counts the paired strobes as a lost write, would show the wrong interrupt. The idle timeout is checked at limits of 1, 3 and 0 and restarted by a push, which catches off-by-one tick counting and a zero limit that fires at once. Flush pulses are checked for width and for clearing overflow, and writes to the fill readback word for having no effect.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   // interrupt source positions; mask field and status field share this order
   localparam int SRC_RX_OVER  = 0;
   localparam int SRC_RX_LEVEL = 1;
   localparam int SRC_RX_IDLE  = 2;
   localparam int SRC_TX_EMPTY = 3;
   localparam int SRC_TX_LOW   = 4;
   localparam int NUM_SRC      = 5;

   // register words
   typedef enum logic [1:0] {
      W_IRQ   = 2'd0,
      W_LEVEL = 2'd1,
      W_CTRL  = 2'd2,
      W_FILL  = 2'd3
   } reg_word_e;

   // bit placement inside the words
   localparam int MASK_LSB   = 0;
   localparam int STAT_LSB   = 8;
   localparam int RXNE_BIT   = 15;
   localparam int RXTHR_LSB  = 0;
   localparam int TXTHR_LSB  = 8;
   localparam int TMO_LSB    = 0;
   localparam int FL_RX_BIT  = 8;
   localparam int FL_TX_BIT  = 9;
endpackage

// File: rtl/uirq_rx_status.sv
module uirq_rx_status #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5,
   parameter int TMO_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [CNT_W-1:0] count,
   input  logic             char_tick,
   input  logic [CNT_W-1:0] thr,
   input  logic [TMO_W-1:0] tmo_lim,
   input  logic             flush,
   output logic             st_over,
   output logic             st_level,
   output logic             st_idle,
   output logic             not_empty
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic             over_q;
   logic [TMO_W-1:0] idle_cnt;
   logic             lost_write;
   logic             restart;

   assign lost_write = push && !pop && (count >= FULL);
   assign restart    = push || pop || flush || (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          over_q <= 1'b0;
      else if (flush)      over_q <= 1'b0;
      else if (lost_write) over_q <= 1'b1;
      else if (pop)        over_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              idle_cnt <= '0;
      else if (restart)                        idle_cnt <= '0;
      else if (char_tick && idle_cnt < tmo_lim) idle_cnt <= idle_cnt + 1'b1;
   end

   assign st_over   = over_q;
   assign not_empty = (count != '0);
   assign st_level  = (count > thr);
   assign st_idle   = not_empty && (tmo_lim != '0) && (idle_cnt >= tmo_lim);

   // R2: a write into a full queue is remembered
   a_r2_ovf_set : assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && count == FULL && !flush) |=> st_over);
   // R2: overflow holds until a pop or flush
   a_r2_ovf_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (st_over && !pop && !flush) |=> st_over);
   // R4: any strobe restarts the idle timer
   a_r4_idle_restart : assert property (@(posedge clk) disable iff (!rst_n)
      (push || pop) |=> !st_idle);
   // R10: receive flush clears overflow
   a_r10_flush_clears : assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !st_over);
endmodule

// File: rtl/uirq_tx_status.sv
module uirq_tx_status #(
   parameter int CNT_W = 5
) (
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] thr,
   output logic             st_empty,
   output logic             st_low
);
   assign st_empty = (count == '0);
   assign st_low   = (count < thr);
endmodule

// File: rtl/uirq_regs.sv
module uirq_regs
   import uart_irq_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int CNT_W  = 5,
   parameter int TMO_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_SRC-1:0] status,
   input  logic              rx_not_empty,
   input  logic [CNT_W-1:0]  tx_count,
   output logic [NUM_SRC-1:0] mask,
   output logic [CNT_W-1:0]  rx_thr,
   output logic [CNT_W-1:0]  tx_thr,
   output logic [TMO_W-1:0]  tmo_lim,
   output logic              rx_flush,
   output logic              tx_flush
);
   localparam logic [CNT_W-1:0] THR_RST = CNT_W'(DEPTH / 2);
   localparam logic [TMO_W-1:0] TMO_RST = TMO_W'(1);

   logic wr_irq, wr_lvl, wr_ctl;
   assign wr_irq = reg_wr && (reg_addr == W_IRQ);
   assign wr_lvl = reg_wr && (reg_addr == W_LEVEL);
   assign wr_ctl = reg_wr && (reg_addr == W_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask     <= '0;
         rx_thr   <= THR_RST;
         tx_thr   <= THR_RST;
         tmo_lim  <= TMO_RST;
         rx_flush <= 1'b0;
         tx_flush <= 1'b0;
      end else begin
         if (wr_irq) mask <= reg_wdata[MASK_LSB +: NUM_SRC];
         if (wr_lvl) begin
            rx_thr <= reg_wdata[RXTHR_LSB +: CNT_W];
            tx_thr <= reg_wdata[TXTHR_LSB +: CNT_W];
         end
         if (wr_ctl) tmo_lim <= reg_wdata[TMO_LSB +: TMO_W];
         rx_flush <= wr_ctl && reg_wdata[FL_RX_BIT];
         tx_flush <= wr_ctl && reg_wdata[FL_TX_BIT];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         W_IRQ: begin
            reg_rdata[MASK_LSB +: NUM_SRC] = mask;
            reg_rdata[STAT_LSB +: NUM_SRC] = status;
            reg_rdata[RXNE_BIT]            = rx_not_empty;
         end
         W_LEVEL: begin
            reg_rdata[RXTHR_LSB +: CNT_W] = rx_thr;
            reg_rdata[TXTHR_LSB +: CNT_W] = tx_thr;
         end
         W_CTRL:  reg_rdata[TMO_LSB +: TMO_W] = tmo_lim;
         default: reg_rdata[CNT_W-1:0] = tx_count;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;

   // R10: flush outputs are single-cycle pulses
   a_r10_rx_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ctl && reg_wdata[FL_RX_BIT]) |=> !rx_flush);
   a_r10_tx_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ctl && reg_wdata[FL_TX_BIT]) |=> !tx_flush);
   // R7: mask changes only through a write to the interrupt word
   a_r7_mask_stable : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_irq |=> $stable(mask));
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
   import uart_irq_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int TMO_W   = 4,
   parameter int DATA_W  = 16,
   parameter bit IRQ_REG = 1'b0,
   localparam int CNT_W  = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_push,
   input  logic              rx_pop,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic              char_tick,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq,
   output logic              rx_flush,
   output logic              tx_flush
);
   // elaboration checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 16) begin : g_bad_width
      $error("DATA_W must hold the 16-bit register layout");
   end
   if (CNT_W > 5 || TMO_W > 8 || TMO_W < 1) begin : g_bad_field
      $error("threshold or timeout field overlaps a neighbour");
   end

   logic [NUM_SRC-1:0] status, mask;
   logic [CNT_W-1:0]   rx_thr, tx_thr;
   logic [TMO_W-1:0]   tmo_lim;
   logic               rx_ne;

   uirq_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W), .TMO_W(TMO_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status(status),
      .rx_not_empty(rx_ne), .tx_count(tx_count), .mask(mask),
      .rx_thr(rx_thr), .tx_thr(tx_thr), .tmo_lim(tmo_lim),
      .rx_flush(rx_flush), .tx_flush(tx_flush));

   uirq_rx_status #(.DEPTH(DEPTH), .CNT_W(CNT_W), .TMO_W(TMO_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
      .count(rx_count), .char_tick(char_tick), .thr(rx_thr),
      .tmo_lim(tmo_lim), .flush(rx_flush),
      .st_over(status[SRC_RX_OVER]), .st_level(status[SRC_RX_LEVEL]),
      .st_idle(status[SRC_RX_IDLE]), .not_empty(rx_ne));

   uirq_tx_status #(.CNT_W(CNT_W)) u_tx (
      .count(tx_count), .thr(tx_thr),
      .st_empty(status[SRC_TX_EMPTY]), .st_low(status[SRC_TX_LOW]));

   logic [NUM_SRC-1:0] pending;
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
      assign pending[i] = status[i] & mask[i];
   end

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |pending;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |pending;
      // R7: an all-zero mask keeps the line quiet
      a_r7_mask_zero_quiet : assert property (@(posedge clk) disable iff (!rst_n)
         (mask == '0) |-> !irq);
   end

   // R6: an empty transmit queue is always below a nonzero threshold
   a_r6_empty_is_low : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count == '0 && tx_thr != '0) |-> status[SRC_TX_LOW]);
   // R1: no flush pulse in the first cycle out of reset
   a_r1_quiet_start : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!rx_flush && !tx_flush));
endmodule

// File: tb/uart_fifo_irq_test.sv
`timescale 1ns/1ps
module uart_fifo_irq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_push = 1'b0, rx_pop = 1'b0, char_tick = 1'b0;
   logic [4:0]  rx_count = 5'd0, tx_count = 5'd10;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        irq, rx_flush, tx_flush;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   uart_fifo_irq uut (
      .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop),
      .rx_count(rx_count), .tx_count(tx_count), .char_tick(char_tick),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq), .rx_flush(rx_flush), .tx_flush(tx_flush));

   // scoreboard of expected register reads
   logic [15:0] exp_q[$];
   string       tag_q[$];
   event        sample_ev;

   initial begin
      forever begin
         @(sample_ev);
         if (exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (reg_rdata !== e) begin
               fails++;
               $display("FAIL %s: rdata got %h expected %h", t, reg_rdata, e);
            end
         end
      end
   end

   task automatic rd_exp(input logic [1:0] a, input logic [15:0] e, input string t);
      @(negedge clk);
      reg_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      #1 ->sample_ev;
      #0.5;
   endtask

   task automatic bit_chk(input logic got, input logic e, input string t);
      checks++;
      if (got !== e) begin
         fails++;
         $display("FAIL %s: got %b expected %b", t, got, e);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic pulse_push();
      @(negedge clk); rx_push = 1'b1;
      @(negedge clk); rx_push = 1'b0;
   endtask

   task automatic pulse_pop();
      @(negedge clk); rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); char_tick = 1'b1;
         @(negedge clk); char_tick = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      bit_chk(irq, 1'b0, "R1 irq");
      bit_chk(rx_flush, 1'b0, "R1 rx_flush");
      bit_chk(tx_flush, 1'b0, "R1 tx_flush");
      rd_exp(2'd0, 16'h0000, "R1 irq word");
      rd_exp(2'd1, 16'h0808, "R1 thresholds");
      rd_exp(2'd2, 16'h0001, "R1 timeout");
      // R8 fill readback
      rd_exp(2'd3, 16'h000A, "R8 fill 10");
      tx_count = 5'd5;
      rd_exp(2'd3, 16'h0005, "R8 fill 5");
      rd_exp(2'd0, 16'h1000, "R6 below threshold");
      tx_count = 5'd8;
      rd_exp(2'd0, 16'h0000, "R6 equal threshold");
      tx_count = 5'd0;
      rd_exp(2'd0, 16'h1800, "R5 empty");
      tx_count = 5'd7;
      wr(2'd3, 16'h001F);
      rd_exp(2'd3, 16'h0007, "R11 fill word write ignored");
      tx_count = 5'd10;
      // R3 / R9 receive level
      rx_count = 5'd8;
      rd_exp(2'd0, 16'h8000, "R9 not empty only");
      bit_chk(irq, 1'b0, "R9 no interrupt");
      rx_count = 5'd9;
      rd_exp(2'd0, 16'h8200, "R3 above 8");
      wr(2'd1, 16'h0803);
      rd_exp(2'd1, 16'h0803, "R3 threshold write");
      rx_count = 5'd3;
      rd_exp(2'd0, 16'h8000, "R3 equal 3");
      rx_count = 5'd4;
      rd_exp(2'd0, 16'h8200, "R3 above 3");
      // R7 masking
      wr(2'd0, 16'h0002);
      bit_chk(irq, 1'b1, "R7 level masked in");
      rd_exp(2'd0, 16'h8202, "R7 mask readback");
      wr(2'd0, 16'h0010);
      bit_chk(irq, 1'b0, "R7 other source idle");
      wr(2'd0, 16'h0002);
      wr(2'd0, 16'h0000);
      bit_chk(irq, 1'b0, "R7 zero mask drops");
      // R2 overflow
      rx_count = 5'd16;
      wr(2'd0, 16'h0001);
      bit_chk(irq, 1'b0, "R2 full but no lost write");
      pulse_push();
      bit_chk(irq, 1'b1, "R2 overflow raised");
      rd_exp(2'd0, 16'h8301, "R2 overflow status");
      repeat (3) @(negedge clk);
      bit_chk(irq, 1'b1, "R2 overflow sticky");
      pulse_pop();
      rd_exp(2'd0, 16'h8201, "R2 cleared by pop");
      @(negedge clk); rx_push = 1'b1; rx_pop = 1'b1;
      @(negedge clk); rx_push = 1'b0; rx_pop = 1'b0;
      bit_chk(irq, 1'b0, "R2 push with pop no overflow");
      // R4 idle timeout
      rx_count = 5'd4;
      wr(2'd0, 16'h0004);
      bit_chk(irq, 1'b0, "R4 before tick");
      ticks(1);
      bit_chk(irq, 1'b1, "R4 one character time");
      rd_exp(2'd0, 16'h8604, "R4 timeout status");
      pulse_push();
      bit_chk(irq, 1'b0, "R4 push restarts");
      wr(2'd2, 16'h0003);
      ticks(2);
      bit_chk(irq, 1'b0, "R4 two of three");
      ticks(1);
      bit_chk(irq, 1'b1, "R4 three of three");
      wr(2'd2, 16'h0000);
      ticks(5);
      bit_chk(irq, 1'b0, "R4 zero limit disables");
      wr(2'd2, 16'h0001);
      ticks(1);
      bit_chk(irq, 1'b1, "R4 limit one again");
      rx_count = 5'd0;
      @(negedge clk);
      bit_chk(irq, 1'b0, "R4 empty queue clears");
      // R10 flush
      rx_count = 5'd16;
      wr(2'd0, 16'h0001);
      pulse_push();
      bit_chk(irq, 1'b1, "R10 overflow before flush");
      wr(2'd2, 16'h0101);
      bit_chk(rx_flush, 1'b1, "R10 rx flush pulse");
      bit_chk(tx_flush, 1'b0, "R10 tx flush idle");
      @(negedge clk);
      bit_chk(rx_flush, 1'b0, "R10 rx flush self clears");
      bit_chk(irq, 1'b0, "R10 flush clears overflow");
      rd_exp(2'd2, 16'h0001, "R10 flush bits read zero");
      wr(2'd2, 16'h0201);
      bit_chk(tx_flush, 1'b1, "R10 tx flush pulse");
      bit_chk(rx_flush, 1'b0, "R10 rx flush idle");
      @(negedge clk);
      bit_chk(tx_flush, 1'b0, "R10 tx flush self clears");
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule